// File: doc/BRIEF.md
# Vertical Charge-Sweep Burst Generator

This block clears stale charge out of an image sensor's vertical transfer registers ahead of a still-frame readout. It does this by running a long burst of fast vertical transfers. Software or a mode sequencer raises a sweep request. The block holds that request pending until the sweep start point, which is a chosen line and horizontal count. From there it produces back-to-back transfer cells of 24 pixel clocks each, until 780 cells have been issued. A line lasts 1560 pixel clocks, which is a multiple of the cell length. The cells therefore land on counts 2, 26, 50 and so on in every line, and the burst continues without a break across line ends. It also continues across the frame wrap from line 525 to line 1.

Each cell drives two phase groups in turn. The first group is enabled for the first 12 clocks of the cell and the second group for the last 12, so the two groups are 12 clocks apart. These sweep enables are meant to be merged onto the vertical phase drivers. While the burst runs, the block forces the normal per-line vertical enables to zero, so the two sources never drive the phases together. A busy flag covers the whole burst, and a one-clock done pulse marks its end.

Top module: `ccd_sweep_gen`

## Requirements
- R1: After reset, `busy`, `done` and `sweep_ph` are 0, and `vclk_out` equals `vclk_in`.
- R2: `sweep_req` is accepted only when no sweep is pending and none is running. A request at any other time is ignored and never causes a second burst.
- R3: A pending sweep starts at the first rising edge that samples `line_num` = START_LINE (default 520) and `h_cnt` = FIRST_H (default 2). `busy` is high from the following cycle on.
- R4: Each cell lasts CELL (24) clocks. `sweep_ph[0]` is high for its first HALF (12) clocks and `sweep_ph[1]` for its last 12. While busy, exactly one bit is high, and it is never both.
- R5: Exactly STAGES (780) cells are issued, so `busy` stays high for 780×24 cycles. `busy` then falls in the same cycle that `done` is high for exactly one clock.
- R6: The cell cadence and the stage count continue unbroken across line ends and across the frame wrap from line 525 to line 1.
- R7: While `busy` is high, `vclk_out` is all zero. Otherwise `vclk_out` equals `vclk_in` in the same cycle.
- R8: A pending request is held across any number of lines, without touching any output, until the start point is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | H_W (11) | Horizontal pixel count within the line |
| line_num | input | L_W (10) | Current line number |
| sweep_req | input | 1 | Sweep request |
| vclk_in | input | NORM_W (6) | Normal per-line vertical phase enables |
| vclk_out | output | NORM_W (6) | Normal enables after gating by the sweep |
| sweep_ph | output | 2 | Sweep phase-group enables (bit 0 first half of cell, bit 1 second half) |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock pulse at the end of the burst |

## Verification
Each problem in the internal state shows up at the ports in a predictable way. A cell-offset counter that is off by one skews the 12/12 split of `sweep_ph` within the first cell. A stage counter that is wrong moves the fall of `busy` and the `done` pulse away from cycle 18720 of the burst. A pending flag that is latched at the wrong time causes a burst on a later pass through the start line, or misses one. The bench predicts every cycle's outputs and compares them one clock after each edge, so any of these faults shows up within one cycle of the point where it diverges.

// File: rtl/ccd_sweep_gen.sv
module ccd_sweep_gen #(
  parameter int H_W        = 11,
  parameter int L_W        = 10,
  parameter int NORM_W     = 6,
  parameter int STAGES     = 780,
  parameter int CELL       = 24,
  parameter int HALF       = 12,
  parameter int FIRST_H    = 2,
  parameter int START_LINE = 520
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    h_cnt,
  input  logic [L_W-1:0]    line_num,
  input  logic              sweep_req,
  input  logic [NORM_W-1:0] vclk_in,
  output logic [NORM_W-1:0] vclk_out,
  output logic [1:0]        sweep_ph,
  output logic              busy,
  output logic              done
);
  localparam int O_W = $clog2(CELL);
  localparam int S_W = $clog2(STAGES + 1);
  localparam logic [O_W-1:0] LAST_OFF = O_W'(CELL - 1);
  localparam logic [S_W-1:0] LAST_STG = S_W'(STAGES - 1);

  logic           pend, run, done_r;
  logic [O_W-1:0] off;
  logic [S_W-1:0] stg;
  logic           at_start;

  assign at_start = (line_num == L_W'(START_LINE)) && (h_cnt == H_W'(FIRST_H));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      run    <= 1'b0;
      done_r <= 1'b0;
      off    <= '0;
      stg    <= '0;
    end else begin
      done_r <= 1'b0;
      if (!pend && !run && sweep_req)
        pend <= 1'b1;
      if (run) begin
        if (off == LAST_OFF) begin
          off <= '0;
          if (stg == LAST_STG) begin
            run    <= 1'b0;
            stg    <= '0;
            done_r <= 1'b1;
          end else begin
            stg <= stg + 1'b1;
          end
        end else begin
          off <= off + 1'b1;
        end
      end else if (pend && at_start) begin
        run  <= 1'b1;
        pend <= 1'b0;
        off  <= '0;
        stg  <= '0;
      end
    end
  end

  assign sweep_ph[0] = run && (off <  O_W'(HALF));
  assign sweep_ph[1] = run && (off >= O_W'(HALF));
  assign busy        = run;
  assign done        = done_r;
  assign vclk_out    = run ? '0 : vclk_in;
endmodule

// File: rtl/ccd_sweep_gen_chk.sv
module ccd_sweep_gen_chk #(
  parameter int H_W        = 11,
  parameter int L_W        = 10,
  parameter int NORM_W     = 6,
  parameter int STAGES     = 780,
  parameter int CELL       = 24,
  parameter int HALF       = 12,
  parameter int FIRST_H    = 2,
  parameter int START_LINE = 520
) (
  input logic              clk,
  input logic              rst_n,
  input logic [H_W-1:0]    h_cnt,
  input logic [L_W-1:0]    line_num,
  input logic [NORM_W-1:0] vclk_in,
  input logic [NORM_W-1:0] vclk_out,
  input logic [1:0]        sweep_ph,
  input logic              busy,
  input logic              done
);
  localparam int TOTAL = STAGES * CELL;
  localparam int C_W   = $clog2(TOTAL + 1) + 1;
  logic [C_W-1:0] run_len;
  logic [5:0]     grp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else if (!done) run_len <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_len <= '0;
    else if (!busy || (sweep_ph != $past(sweep_ph))) grp_len <= 6'd1;
    else grp_len <= grp_len + 1'b1;
  end

  AST_GROUPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sweep_ph)); // R4
  AST_ONE_GROUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> $countones(sweep_ph) == 1); // R4
  AST_GROUP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) busy |-> grp_len <= 6'(HALF)); // R4
  AST_START_POINT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ($past(line_num) == L_W'(START_LINE) && $past(h_cnt) == H_W'(FIRST_H))); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) done |-> run_len == C_W'(TOTAL)); // R5
  AST_NORM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> vclk_out == '0); // R7
  AST_NORM_PASS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> vclk_out == vclk_in); // R7
endmodule

bind ccd_sweep_gen ccd_sweep_gen_chk #(
  .H_W(H_W), .L_W(L_W), .NORM_W(NORM_W), .STAGES(STAGES), .CELL(CELL),
  .HALF(HALF), .FIRST_H(FIRST_H), .START_LINE(START_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_num(line_num),
  .vclk_in(vclk_in), .vclk_out(vclk_out), .sweep_ph(sweep_ph),
  .busy(busy), .done(done)
);

// File: tb/test_ccd_sweep_gen.sv
module test_ccd_sweep_gen;
  typedef struct {
    logic       busy;
    logic       done;
    logic [1:0] ph;
    logic [5:0] vout;
    string      tag;
  } exp_t;

  logic clk = 0, rst_n = 0, sweep_req = 0;
  logic [10:0] h_cnt = 0;
  logic [9:0]  line_num = 1;
  logic [5:0]  vclk_in = 0, vclk_out;
  logic [1:0]  sweep_ph;
  logic        busy, done;

  ccd_sweep_gen i_ccd_sweep_gen (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_num(line_num),
    .sweep_req(sweep_req), .vclk_in(vclk_in), .vclk_out(vclk_out),
    .sweep_ph(sweep_ph), .busy(busy), .done(done));

  always #4 clk = ~clk;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  int h = 0, ln = 515;
  string tag = "R1";
  logic [5:0] lfsr = 6'h2B;
  logic m_pend = 0, m_run = 0, m_done = 0;
  int m_off = 0, m_stg = 0;

  task automatic tick(input logic rst_v, input logic req_v);
    exp_t e;
    logic op, orun;
    @(negedge clk);
    rst_n = rst_v; sweep_req = req_v;
    h_cnt = 11'(h); line_num = 10'(ln);
    lfsr = {lfsr[4:0], lfsr[5] ^ lfsr[4]};
    vclk_in = lfsr;
    op = m_pend; orun = m_run;
    if (!rst_v) begin
      m_pend = 0; m_run = 0; m_done = 0; m_off = 0; m_stg = 0;
    end else begin
      m_done = 0;
      if (orun) begin
        if (m_off == 23) begin
          m_off = 0;
          if (m_stg == 779) begin m_run = 0; m_stg = 0; m_done = 1; end
          else m_stg++;
        end else m_off++;
      end else if (op && ln == 520 && h == 2) begin
        m_run = 1; m_pend = 0; m_off = 0; m_stg = 0;
      end
      if (!op && !orun && req_v) m_pend = 1;
    end
    e.busy = m_run; e.done = m_done;
    e.ph   = m_run ? ((m_off < 12) ? 2'b01 : 2'b10) : 2'b00;
    e.vout = m_run ? 6'h00 : lfsr;
    e.tag  = tag;
    q.push_back(e);
    h++;
    if (h == 1560) begin h = 0; ln = (ln == 525) ? 1 : ln + 1; end
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        logic bad;
        e = q.pop_front();
        bad = 0;
        n_cmp++;
        if (busy !== e.busy) begin bad = 1; $display("FAIL %s busy: actual %0b expected %0b", e.tag, busy, e.busy); end
        if (done !== e.done) begin bad = 1; $display("FAIL %s done (R5): actual %0b expected %0b", e.tag, done, e.done); end
        if (sweep_ph !== e.ph) begin bad = 1; $display("FAIL %s sweep_ph (R4): actual %b expected %b", e.tag, sweep_ph, e.ph); end
        if (vclk_out !== e.vout) begin bad = 1; $display("FAIL %s vclk_out (R7): actual %h expected %h", e.tag, vclk_out, e.vout); end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tag = "R1";
    for (int i = 0; i < 4; i++) tick(0, 0);
    tag = "R8";
    tick(1, 1);
    for (int i = 0; i < 3000; i++) tick(1, 0);
    tag = "R2";
    tick(1, 1);
    tag = "R8";
    while (!(ln == 520 && h == 3)) tick(1, 0);
    tag = "R3";
    for (int i = 0; i < 30; i++) tick(1, 0);
    tag = "R4";
    for (int i = 0; i < 5000; i++) tick(1, 0);
    tag = "R2";
    tick(1, 1);
    tag = "R4";
    while (!m_done) begin
      if ((ln == 525 && h >= 1540) || (ln == 1 && h < 30)) tag = "R6";
      else if (!m_run) tag = "R5";
      else tag = "R4";
      tick(1, 0);
    end
    tag = "R5";
    for (int i = 0; i < 4; i++) tick(1, 0);
    tag = "R2";
    ln = 519; h = 1500;
    for (int i = 0; i < 1700; i++) tick(1, 0);
    tag = "R3";
    ln = 520; h = 0;
    tick(1, 1);
    for (int i = 0; i < 30; i++) tick(1, 0);
    tag = "R7";
    while (!m_done) tick(1, 0);
    tag = "R5";
    for (int i = 0; i < 4; i++) tick(1, 0);
    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule